// File: doc/BRIEF.md
# Segmented Wide XOR Parity Reducer

This block folds three 48-bit operands into one or more parity bits. The operands are called x, y and z. In the first step, every bit position of the three operands is combined into a single bit. Those 48 bits then feed a balanced reduction tree. A two-bit segment mode chooses how the tree output is read: as eight, four, two or one parity segments. Each segment is a contiguous group of bit positions. With eight segments, each one covers 12 bits of any two operands, which is where the nominal 12/24/48/96-bit widths come from.

The result is held in an 8-bit register. Segment i lands at bit i and the bits above the active segments read zero. With the accumulate input high, each new segment parity is XORed into the value already in the register. A parity over a stream that is wider than one operand word can therefore be built up one word per clock. A synchronous clear empties the register. When the enable input is low, the operands are gated away from the tree and the register holds its value.

Top module: `wxr_reduce`

## Requirements
- R1: While rst is high, and on the first cycle after it, par reads 8'h00.
- R2: With mode 2'd0, after a clock edge where en=1, clr=0 and acc=0, par[i] for i=0..7 equals the XOR of x, y and z over bit positions 6i to 6i+5.
- R3: With mode 2'd1, par[i] for i=0..3 equals the XOR of x, y and z over bit positions 12i to 12i+11, and par[7:4] is zero.
- R4: With mode 2'd2, par[i] for i=0..1 equals the XOR of x, y and z over bit positions 24i to 24i+23, and par[7:2] is zero.
- R5: With mode 2'd3, par[0] equals the XOR of all 144 operand bits, and par[7:1] is zero.
- R6: With acc=1 (en=1, clr=0), each active bit of par becomes the segment parity of the current mode XORed with that bit's previous registered value. The inactive upper bits become zero.
- R7: When clr=1 at a clock edge, par becomes 8'h00 regardless of en, acc, mode and the operands.
- R8: When en=0 and clr=0 at a clock edge, par keeps its previous value whatever x, y, z, mode and acc do.
- R9: par updates one clock edge after the inputs it reflects: there is exactly one register between the operands and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the result register |
| en | input | 1 | Enables the reduction; low gates the operands and holds the result |
| acc | input | 1 | Accumulate the new parity into the held result |
| mode | input | 2 | Segment mode: 0 eight, 1 four, 2 two, 3 one segment |
| x | input | 48 | First operand |
| y | input | 48 | Second operand |
| z | input | 48 | Third operand |
| par | output | 8 | Registered segment parities, segment i at bit i |

## Verification
Suppose the tree pairs the wrong leaves, or the first level drops an operand. A single set operand bit then moves, or fails to move, the parity bit of the wrong segment on the very next edge. For this reason the walking-one patterns are run in every mode. Suppose the register loses state or merges stale upper bits during accumulation. The error then stays visible in every following cycle until a clear, because each cycle's expected value depends on the one before. The stimulus therefore switches mode in the middle of an accumulation and toggles the operands while en is low.

// File: rtl/wxr_pkg.sv
package wxr_pkg;

    localparam int LANE_W  = 48;
    localparam int SEG_MAX = 8;
    localparam int LEAF_W  = LANE_W / SEG_MAX;
    localparam int LEVELS  = $clog2(SEG_MAX);
    localparam int MODE_W  = $clog2(LEVELS + 1);

    typedef enum logic [MODE_W-1:0] {
        SEG_OCT  = 2'd0,
        SEG_QUAD = 2'd1,
        SEG_DUAL = 2'd2,
        SEG_ONE  = 2'd3
    } seg_mode_e;

    typedef struct packed {
        logic      clr;
        logic      en;
        logic      acc;
        seg_mode_e mode;
    } wxr_ctl_s;

    typedef logic [SEG_MAX-1:0] seg_vec_t;

    function automatic int seg_count(seg_mode_e m);
        return SEG_MAX >> int'(m);
    endfunction

    function automatic seg_vec_t active_mask(seg_mode_e m);
        seg_vec_t msk;
        msk = '0;
        for (int i = 0; i < SEG_MAX; i++) begin
            if (i < seg_count(m)) begin
                msk[i] = 1'b1;
            end
        end
        return msk;
    endfunction

endpackage

// File: rtl/wxr_first_level.sv
module wxr_first_level
    import wxr_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         gate,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] t
);

    // Operand isolation: when gate is low the tree sees constant zeros.
    logic [W-1:0] xg;
    logic [W-1:0] yg;
    logic [W-1:0] zg;

    always_comb begin
        xg = x & {W{gate}};
        yg = y & {W{gate}};
        zg = z & {W{gate}};
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign t[b] = xg[b] ^ yg[b] ^ zg[b];
    end

endmodule

// File: rtl/wxr_fold_tree.sv
module wxr_fold_tree
    import wxr_pkg::*;
#(
    parameter int W    = LANE_W,
    parameter int SEGS = SEG_MAX,
    localparam int LW  = W / SEGS,
    localparam int LV  = $clog2(SEGS)
) (
    input  logic [W-1:0]             t,
    output logic [LV:0][SEGS-1:0]    lvl
);

    // Level 0: one parity per leaf of LW bits.
    for (genvar i = 0; i < SEGS; i++) begin : g_leaf
        assign lvl[0][i] = ^t[i*LW +: LW];
    end

    // Each higher level pairs neighbours of the level below.
    for (genvar k = 1; k <= LV; k++) begin : g_level
        for (genvar i = 0; i < SEGS; i++) begin : g_node
            if (i < (SEGS >> k)) begin : g_pair
                assign lvl[k][i] = lvl[k-1][2*i] ^ lvl[k-1][2*i+1];
            end else begin : g_pad
                assign lvl[k][i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wxr_seg_select.sv
module wxr_seg_select
    import wxr_pkg::*;
#(
    parameter int SEGS = SEG_MAX,
    localparam int LV  = $clog2(SEGS)
) (
    input  seg_mode_e               mode,
    input  logic [LV:0][SEGS-1:0]   lvl,
    output logic [SEGS-1:0]         seg,
    output logic [SEGS-1:0]         mask
);

    always_comb begin
        seg  = '0;
        mask = '0;
        for (int k = 0; k <= LV; k++) begin
            if (int'(mode) == k) begin
                seg = lvl[k];
                for (int i = 0; i < SEGS; i++) begin
                    mask[i] = (i < (SEGS >> k));
                end
            end
        end
    end

endmodule

// File: rtl/wxr_result_reg.sv
module wxr_result_reg
    import wxr_pkg::*;
#(
    parameter int SEGS = SEG_MAX
) (
    input  logic            clk,
    input  logic            rst,
    input  wxr_ctl_s        ctl,
    input  logic [SEGS-1:0] seg,
    input  logic [SEGS-1:0] mask,
    output logic [SEGS-1:0] q
);

    logic [SEGS-1:0] fold;
    logic [SEGS-1:0] nxt;

    always_comb begin
        fold = ctl.acc ? q : '0;
        nxt  = (seg ^ fold) & mask;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            q <= '0;
        end else if (ctl.en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/wxr_reduce.sv
module wxr_reduce
    import wxr_pkg::*;
#(
    parameter int W    = LANE_W,
    parameter int SEGS = SEG_MAX,
    localparam int LV  = $clog2(SEGS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         acc,
    input  logic [1:0]   mode,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [SEGS-1:0] par
);

    wxr_ctl_s              ctl;
    logic [W-1:0]          t;
    logic [LV:0][SEGS-1:0] lvl;
    logic [SEGS-1:0]       seg;
    logic [SEGS-1:0]       mask;

    always_comb begin
        ctl.clr  = clr;
        ctl.en   = en;
        ctl.acc  = acc;
        ctl.mode = seg_mode_e'(mode);
    end

    wxr_first_level #(.W(W)) u_first (
        .gate (en),
        .x    (x),
        .y    (y),
        .z    (z),
        .t    (t)
    );

    wxr_fold_tree #(.W(W), .SEGS(SEGS)) u_tree (
        .t   (t),
        .lvl (lvl)
    );

    wxr_seg_select #(.SEGS(SEGS)) u_sel (
        .mode (ctl.mode),
        .lvl  (lvl),
        .seg  (seg),
        .mask (mask)
    );

    wxr_result_reg #(.SEGS(SEGS)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .seg  (seg),
        .mask (mask),
        .q    (par)
    );

endmodule

// File: rtl/wxr_reduce_chk.sv
module wxr_reduce_chk
    import wxr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        clr,
    input logic        en,
    input logic        acc,
    input logic [1:0]  mode,
    input logic [47:0] x,
    input logic [47:0] y,
    input logic [47:0] z,
    input logic [7:0]  par
);

    // R7: clear empties the register on the next edge.
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !$past(rst)) |=> (par == 8'h00));

    // R8: disabled cycles leave the result untouched.
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(par));

    // R3/R4/R5/R6: bits above the active segment count are zero after an update.
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> ((par & ~active_mask(seg_mode_e'($past(mode)))) == 8'h00));

    // R5: single segment is the parity of all operand bits.
    p_single_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !acc && mode == 2'd3) |=> (par[0] == ^($past(x) ^ $past(y) ^ $past(z))));

    // R6: accumulation in single mode folds the held bit.
    p_acc_single_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && acc && mode == 2'd3 && !$past(rst))
        |=> (par[0] == ($past(par[0]) ^ (^($past(x) ^ $past(y) ^ $past(z))))));

    // R1: first cycle out of reset reads zero.
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (par == 8'h00));

endmodule

bind wxr_reduce wxr_reduce_chk chk_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .en   (en),
    .acc  (acc),
    .mode (mode),
    .x    (x),
    .y    (y),
    .z    (z),
    .par  (par)
);

// File: tb/wxr_reduce_tb_top.sv
module wxr_reduce_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr;
    logic        en;
    logic        acc;
    logic [1:0]  mode;
    logic [47:0] x;
    logic [47:0] y;
    logic [47:0] z;
    logic [7:0]  par;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    wxr_reduce dut_i (
        .clk(clk), .rst(rst), .clr(clr), .en(en), .acc(acc), .mode(mode),
        .x(x), .y(y), .z(z), .par(par)
    );

    function automatic logic [7:0] ref_parity(logic [1:0] m, logic [47:0] a,
                                               logic [47:0] b, logic [47:0] c);
        logic [7:0] r;
        int nseg;
        int width;
        r = 8'h00;
        nseg = 8 >> m;
        width = 48 / nseg;
        for (int s = 0; s < nseg; s++) begin
            for (int k = 0; k < width; k++) begin
                r[s] = r[s] ^ a[s*width+k] ^ b[s*width+k] ^ c[s*width+k];
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_mask(logic [1:0] m);
        logic [7:0] r;
        r = 8'h00;
        for (int s = 0; s < (8 >> m); s++) r[s] = 1'b1;
        return r;
    endfunction

    function automatic logic [47:0] rnd48();
        return {$urandom_range(65535, 0), $urandom()};
    endfunction

    // One clock: inputs are already applied; model follows the edge;
    // output is compared at the next falling edge (R9: one register of latency).
    task automatic cyc();
        string tag;
        if (rst)       tag = "R1";
        else if (clr)  tag = "R7";
        else if (!en)  tag = "R8";
        else if (acc)  tag = "R6";
        else if (mode == 2'd0) tag = "R2";
        else if (mode == 2'd1) tag = "R3";
        else if (mode == 2'd2) tag = "R4";
        else           tag = "R5";
        @(posedge clk);
        if (rst || clr) model = 8'h00;
        else if (en) model = (ref_parity(mode, x, y, z) ^ (acc ? model : 8'h00)) & ref_mask(mode);
        @(negedge clk);
        checks++;
        if (par !== model) begin
            errors++;
            $display("FAIL %s/R9: par=%h expected=%h (mode=%0d acc=%b)", tag, par, model, mode, acc);
        end
    endtask

    task automatic rnd_ops();
        x = rnd48(); y = rnd48(); z = rnd48();
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; clr = 1'b0; en = 1'b0; acc = 1'b0; mode = 2'd0;
        x = '1; y = '0; z = '0;
        @(negedge clk);
        // R1: reset state
        repeat (3) cyc();
        rst = 1'b0;
        en = 1'b1;
        cyc();

        // R2..R5: walking one bit in each operand, every mode
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            for (int b = 0; b < 48; b += 5) begin
                x = 48'd1 << b; y = '0; z = '0; cyc();
                x = '0; y = 48'd1 << b; cyc();
                y = '0; z = 48'd1 << b; cyc();
            end
            x = '1; y = '0; z = '0; cyc();
            x = '1; y = '1; z = '1; cyc();
            repeat (20) begin rnd_ops(); cyc(); end
        end

        // R6: accumulate in each mode, then switch mode mid-run
        acc = 1'b1;
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            repeat (12) begin rnd_ops(); cyc(); end
        end
        mode = 2'd0;
        repeat (4) begin rnd_ops(); cyc(); end
        mode = 2'd3;
        rnd_ops(); cyc();
        mode = 2'd1;
        repeat (4) begin rnd_ops(); cyc(); end

        // R8: disabled, with inputs changing
        en = 1'b0;
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0]; acc = m[0];
            rnd_ops(); cyc();
        end
        en = 1'b1; acc = 1'b0; mode = 2'd0;
        rnd_ops(); cyc();

        // R7: clear wins over enable, accumulate and disable
        acc = 1'b1; clr = 1'b1; rnd_ops(); cyc();
        clr = 1'b0; rnd_ops(); cyc();
        en = 1'b0; clr = 1'b1; cyc();
        clr = 1'b0; en = 1'b1; acc = 1'b0;

        // Mixed random control
        repeat (300) begin
            mode = 2'($urandom_range(3, 0));
            acc  = ($urandom_range(3, 0) != 0);
            en   = ($urandom_range(7, 0) != 0);
            clr  = ($urandom_range(15, 0) == 0);
            rnd_ops();
            cyc();
        end

        // R1: reset mid-run
        rst = 1'b1; cyc();
        rst = 1'b0; en = 1'b0; cyc();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule